// File: doc/BRIEF.md
# Compare-Match Interval Timer

This block is a memory-mapped interval timer that sits behind a Wishbone classic slave port with a 32-bit data bus. A programmable divider turns the system clock into count ticks. Each tick advances a 32-bit up-counter. When a tick lands while the count equals a programmable compare value, the timer records a match, may raise an interrupt, and reloads the counter from the value software last wrote into it. The counter then keeps running.

Software sees four word registers. The control word holds a run bit, an interrupt-enable bit and a 16-bit divider. The compare word holds the match value. The counter word returns the live count on a read; a write sets both the count and the reload value. The status word holds two sticky flags that are cleared by writing ones. The bus is not a stream: every strobed access gets exactly one registered acknowledge, and the slave never stalls beyond that one cycle.

Top module: `cmp_timer`

## Requirements
- R1: Each access with cyc and stb high gets ack high for exactly one cycle, on the clock edge after the strobe is seen. The master then drops stb before its next access. Byte selects are ignored, and every write updates the full word.
- R2: Word decode uses byte address bits [ADDR_W-1:2]: 0x00 is control, 0x04 compare, 0x08 counter and 0x0C status. In the control word, bit 0 is run, bit 1 is interrupt enable and bits 31:16 are the divider P. Other control bits read 0. Any other offset reads 0.
- R3: While run is 1, a tick occurs every P+1 cycles. The first tick falls in the (P+1)-th cycle after run becomes 1. Clearing run restarts the divider from zero.
- R4: A counter read returns the live count. A counter write sets the count and the reload value, and takes priority over a tick in the same cycle. A tick with count equal to compare is a match, and it sets the count to the reload value. Any other tick adds one. As a result, with reload R and compare K, a match comes every (K-R+1)(P+1) cycles.
- R5: Status bit 1 (match) sets on every match, whatever the interrupt-enable bit holds.
- R6: Status bit 0 (pending) sets on a match only when interrupt enable is 1. The irq output equals this bit.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a match and a clear land in the same cycle, the bit ends up set.
- R8: Reset clears control, compare, counter, reload, status and the divider count, so every register reads 0 and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Strobe for this slave |
| wb_we_i | input | 1 | 1 = write, 0 = read |
| wb_adr_i | input | ADDR_W | Byte address |
| wb_dat_i | input | DATA_W | Write data |
| wb_sel_i | input | DATA_W/8 | Byte selects (ignored) |
| wb_dat_o | output | DATA_W | Read data, valid with ack |
| wb_ack_o | output | 1 | One-cycle acknowledge |
| irq_o | output | 1 | Interrupt request (status pending bit) |

## Verification
The bench builds the block with its default parameters: a 32-bit data bus, a 16-bit divider and a 6-bit byte address. The address width leaves twelve unmapped words, so the bench can read offsets 0x10 and 0x3C and check that they return zero. Small divider values (0, 3 and 4) and compare windows of a few counts bring matches within 3 to 15 cycles. This lets the bench time the interrupt edge exactly against the cycle of the enabling write. It also lets it steer a status clear into the same cycle as a match.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // word indices of the register file (byte offset / 4)
  localparam int unsigned IDX_CTRL = 0;
  localparam int unsigned IDX_CMP  = 1;
  localparam int unsigned IDX_CNT  = 2;
  localparam int unsigned IDX_STAT = 3;

  // control word fields
  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_IE_BIT  = 1;
  localparam int unsigned CTRL_DIV_LSB = 16;

  // status word fields
  localparam int unsigned STAT_PEND_BIT  = 0;
  localparam int unsigned STAT_MATCH_BIT = 1;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [PRE_W-1:0] div_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] phase_q;

  // counts up and compares against the live divider, so a new divider
  // takes effect without waiting for a stale period to drain
  assign tick_o = run_i && (phase_q >= div_i);

  always_ff @(posedge clk) begin
    if (rst)                    phase_q <= '0;
    else if (!run_i || tick_o)  phase_q <= '0;
    else                        phase_q <= phase_q + 1'b1;
  end

  // R3: back-to-back ticks only with a divider of zero
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> (!tick_o || div_i == '0));

  // R3: stopping restarts the divider phase
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !tick_o || div_i == '0);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload_q;

  assign cnt_o   = cnt_q;
  assign match_o = tick_i && !ld_i && (cnt_q == cmp_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (ld_i) begin
      cnt_q    <= ld_val_i;
      reload_q <= ld_val_i;
    end else if (match_o) begin
      cnt_q    <= reload_q;
    end else if (tick_i) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  // R4: a software load lands on the next cycle
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    ld_i |=> cnt_q == $past(ld_val_i));

  // R4: a match returns the count to the reload value
  p_reload_r4: assert property (@(posedge clk) disable iff (rst)
    match_o |=> cnt_q == $past(reload_q));

  // R4: without tick or load the count holds
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!tick_i && !ld_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PRE_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc_i,
  input  logic              wb_stb_i,
  input  logic              wb_we_i,
  input  logic [ADDR_W-1:0] wb_adr_i,
  input  logic [DATA_W-1:0] wb_dat_i,
  input  logic [DATA_W/8-1:0] wb_sel_i,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic              wb_ack_o,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              match_i,
  output logic              run_o,
  output logic [PRE_W-1:0]  div_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic              ld_o,
  output logic [DATA_W-1:0] ld_val_o,
  output logic              irq_o
);
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic              ack_q;
  logic              run_q, ie_q, pend_q, flag_q;
  logic [PRE_W-1:0]  div_q;
  logic [DATA_W-1:0] cmp_q, rd_word, rdat_q;
  logic [WIDX_W-1:0] widx;
  logic              take, wr;
  logic              hit_ctrl, hit_cmp, hit_cnt, hit_stat;
  logic              clr_pend, clr_flag;
  logic              unused_bits;

  assign unused_bits = ^{wb_sel_i, wb_adr_i[1:0]};

  assign widx     = wb_adr_i[ADDR_W-1:2];
  assign take     = wb_cyc_i && wb_stb_i && !ack_q;
  assign wr       = take && wb_we_i;
  assign hit_ctrl = (widx == WIDX_W'(IDX_CTRL));
  assign hit_cmp  = (widx == WIDX_W'(IDX_CMP));
  assign hit_cnt  = (widx == WIDX_W'(IDX_CNT));
  assign hit_stat = (widx == WIDX_W'(IDX_STAT));
  assign clr_pend = wr && hit_stat && wb_dat_i[STAT_PEND_BIT];
  assign clr_flag = wr && hit_stat && wb_dat_i[STAT_MATCH_BIT];

  assign ld_o     = wr && hit_cnt;
  assign ld_val_o = wb_dat_i;
  assign run_o    = run_q;
  assign div_o    = div_q;
  assign cmp_o    = cmp_q;
  assign irq_o    = pend_q;
  assign wb_ack_o = ack_q;
  assign wb_dat_o = rdat_q;

  always_comb begin
    rd_word = '0;
    if (hit_ctrl) begin
      rd_word[CTRL_RUN_BIT]              = run_q;
      rd_word[CTRL_IE_BIT]               = ie_q;
      rd_word[CTRL_DIV_LSB +: PRE_W]     = div_q;
    end else if (hit_cmp) begin
      rd_word = cmp_q;
    end else if (hit_cnt) begin
      rd_word = cnt_i;
    end else if (hit_stat) begin
      rd_word[STAT_PEND_BIT]  = pend_q;
      rd_word[STAT_MATCH_BIT] = flag_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      rdat_q <= '0;
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      div_q  <= '0;
      cmp_q  <= '0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ack_q <= take;
      if (take) rdat_q <= rd_word;
      if (wr && hit_ctrl) begin
        run_q <= wb_dat_i[CTRL_RUN_BIT];
        ie_q  <= wb_dat_i[CTRL_IE_BIT];
        div_q <= wb_dat_i[CTRL_DIV_LSB +: PRE_W];
      end
      if (wr && hit_cmp) cmp_q <= wb_dat_i;
      // set beats clear
      flag_q <= (flag_q && !clr_flag) || match_i;
      pend_q <= (pend_q && !clr_pend) || (match_i && ie_q);
    end
  end

  // R1: acknowledge is a single-cycle pulse
  p_ack_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    wb_ack_o |=> !wb_ack_o);

  // R1: every fresh strobe is answered on the next edge
  p_ack_answer_r1: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

  // R5: a match always leaves the match flag set
  p_flag_sets_r5: assert property (@(posedge clk) disable iff (rst)
    match_i |=> flag_q);

  // R6: pending only rises from an enabled match
  p_pend_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> $past(match_i && ie_q));

  // R7: a clear without a coincident match drops the flag
  p_clear_w1c_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_flag && !match_i) |=> !flag_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned PRE_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wb_cyc_i,
  input  logic                wb_stb_i,
  input  logic                wb_we_i,
  input  logic [ADDR_W-1:0]   wb_adr_i,
  input  logic [DATA_W-1:0]   wb_dat_i,
  input  logic [DATA_W/8-1:0] wb_sel_i,
  output logic [DATA_W-1:0]   wb_dat_o,
  output logic                wb_ack_o,
  output logic                irq_o
);
  logic              run, tick, ld, match;
  logic [PRE_W-1:0]  div;
  logic [DATA_W-1:0] cmp, ld_val, cnt;

  tmr_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W)) u_regs (
    .clk(clk), .rst(rst),
    .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
    .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_sel_i(wb_sel_i),
    .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
    .cnt_i(cnt), .match_i(match),
    .run_o(run), .div_o(div), .cmp_o(cmp),
    .ld_o(ld), .ld_val_o(ld_val), .irq_o(irq_o)
  );

  tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run_i(run), .div_i(div), .tick_o(tick)
  );

  tmr_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick), .ld_i(ld), .ld_val_i(ld_val),
    .cmp_i(cmp), .cnt_o(cnt), .match_o(match)
  );
endmodule

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [5:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [3:0]  sel = '0;
  logic [31:0] rdat;
  logic        ack, irq;

  int total = 0;
  int fails = 0;
  int cyc_cnt = 0;
  int stamp = 0;
  logic ack_seen, ack_after, irq_at_ack;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  cmp_timer uut (
    .clk(clk), .rst(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_sel_i(sel),
    .wb_dat_o(rdat), .wb_ack_o(ack), .irq_o(irq)
  );

  // {we, sel, byte address, write data, expected read data}
  localparam int NV = 14;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 4'hF, 8'h00, 32'h0005_0002, 32'h0},
    {1'b0, 4'hF, 8'h00, 32'h0,         32'h0005_0002},
    {1'b1, 4'hF, 8'h00, 32'hFFFF_FFFC, 32'h0},
    {1'b0, 4'hF, 8'h00, 32'h0,         32'hFFFF_0000},
    {1'b1, 4'h1, 8'h04, 32'hA5A5_A5A5, 32'h0},
    {1'b0, 4'hF, 8'h04, 32'h0,         32'hA5A5_A5A5},
    {1'b1, 4'hF, 8'h08, 32'h0000_1234, 32'h0},
    {1'b0, 4'hF, 8'h08, 32'h0,         32'h0000_1234},
    {1'b0, 4'hF, 8'h10, 32'h0,         32'h0},
    {1'b0, 4'hF, 8'h3C, 32'h0,         32'h0},
    {1'b1, 4'hF, 8'h0C, 32'h0000_0003, 32'h0},
    {1'b0, 4'hF, 8'h0C, 32'h0,         32'h0},
    {1'b1, 4'hF, 8'h00, 32'h0,         32'h0},
    {1'b0, 4'hF, 8'h00, 32'h0,         32'h0}
  };
  localparam string VTAG [NV] = '{
    "R2", "R2", "R2", "R2", "R1", "R1", "R4", "R4",
    "R2", "R2", "R7", "R7", "R2", "R2"
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [3:0] s, input logic [7:0] a,
                     input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; sel = s; adr = a[5:0]; wdat = d;
    @(posedge clk);
    #1 stamp = cyc_cnt;
    @(negedge clk);
    q = rdat; ack_seen = ack; irq_at_ack = irq;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
    @(negedge clk);
    ack_after = ack;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, 4'hF, a, d, q);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    bus(1'b0, 4'hF, a, 32'h0, q);
  endtask

  task automatic wait_irq(output int e);
    e = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) begin
        e = cyc_cnt;
        break;
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] q;
    int s, f, g;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R8: reset state
    chk("R8 irq", {31'b0, irq}, 32'h0);
    rd(8'h00, q); chk("R8 ctrl", q, 32'h0);
    rd(8'h04, q); chk("R8 cmp", q, 32'h0);
    rd(8'h08, q); chk("R8 cnt", q, 32'h0);
    rd(8'h0C, q); chk("R8 stat", q, 32'h0);

    // R1: ack pulse shape on a plain read
    chk("R1 ack high", {31'b0, ack_seen}, 32'h1);
    chk("R1 ack one cycle", {31'b0, ack_after}, 32'h0);

    // table of register accesses
    for (int i = 0; i < NV; i++) begin
      bus(VEC[i][76], VEC[i][75:72], VEC[i][71:64], VEC[i][63:32], q);
      if (!VEC[i][76]) chk(VTAG[i], q, VEC[i][31:0]);
    end

    // R3 R6: divider 3, reload 0, compare 2 -> 12 cycles to irq
    wr(8'h04, 32'd2);
    wr(8'h08, 32'd0);
    wr(8'h00, 32'h0003_0003); s = stamp;
    wait_irq(f);
    chk("R3 first match timing", f - s, 32'd12);
    chk("R6 irq follows pending", {31'b0, irq}, 32'h1);
    wr(8'h00, 32'h0003_0002);
    rd(8'h0C, q); chk("R5 R6 status after match", q, 32'h3);
    wr(8'h0C, 32'h3);
    rd(8'h0C, q); chk("R7 cleared", q, 32'h0);

    // R3: stopping restarts the divider phase
    wr(8'h00, 32'h0003_0003);
    wr(8'h00, 32'h0003_0002);
    wr(8'h08, 32'd0);
    wr(8'h00, 32'h0003_0003); s = stamp;
    wait_irq(f);
    chk("R3 restart after stop", f - s, 32'd12);
    wr(8'h00, 32'h0003_0002);
    wr(8'h0C, 32'h3);

    // R4 R7: divider 4, reload 5, compare 7 -> 15 cycles per match
    wr(8'h00, 32'h0004_0002);
    wr(8'h04, 32'd7);
    wr(8'h08, 32'd5);
    wr(8'h00, 32'h0004_0003); s = stamp;
    wait_irq(f);
    chk("R4 loaded count timing", f - s, 32'd15);
    wr(8'h0C, 32'h3);
    chk("R7 clear drops irq", {31'b0, irq_at_ack}, 32'h0);
    wait_irq(g);
    chk("R4 reload and keep running", g - f, 32'd15);
    wr(8'h00, 32'h0004_0002);
    wr(8'h0C, 32'h3);

    // R7: clear in the same cycle as a match, divider 0 -> 3 cycles
    wr(8'h08, 32'd5);
    wr(8'h00, 32'h0000_0003); s = stamp;
    wait_irq(f);
    chk("R3 divider zero timing", f - s, 32'd3);
    @(negedge clk);
    wr(8'h0C, 32'h3);
    chk("R7 clear aligned with match", stamp - f, 32'd3);
    chk("R7 set wins over clear", {31'b0, irq_at_ack}, 32'h1);
    wr(8'h00, 32'h0);
    wr(8'h0C, 32'h3);
    rd(8'h0C, q); chk("R7 cleared after stop", q, 32'h0);

    // R5 R6: match with interrupt enable off
    wr(8'h08, 32'd5);
    wr(8'h00, 32'h0000_0001);
    g = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq) g++;
    end
    wr(8'h00, 32'h0);
    chk("R6 no irq when disabled", g, 32'd0);
    rd(8'h0C, q); chk("R5 flag without enable", q, 32'h2);
    wr(8'h0C, 32'h0);
    rd(8'h0C, q); chk("R7 zero write keeps flag", q, 32'h2);
    wr(8'h0C, 32'h2);
    rd(8'h0C, q); chk("R7 one write clears flag", q, 32'h0);

    finish_run();
  end
endmodule